// File: doc/BRIEF.md
# Posted-Write Parity Error Handler for a Two-Port Bus Bridge

This block sits in the data path of a two-port bus bridge and handles data parity errors on posted memory writes in both directions. For each data phase the bridge accepts as target, it takes the parity-check result computed elsewhere and does three things. It sets a sticky "parity error detected" status bit for that side. If parity error response is enabled for that side, it drives the side's active-low parity-error line two clocks later. It stores an error flag beside the data word in the posted-write buffer, so that bad parity is regenerated when the word is driven on the far bus. A write with bad parity is still accepted and completes normally.

The block also watches the parity-error line driven by the target of a downstream write on the secondary bus. When that line is reported and secondary parity response is on, it records a data-parity-detected status bit. It raises a one-clock system-error pulse on the primary side, and sets a signaled-system-error status bit, only when four configuration conditions all hold at once. Software clears each status bit through its own write-one-to-clear strobe.

Top module: `pw_parity_guard`

## Requirements
- R1: When a primary data phase is accepted at rising edge k (`p_wr_valid` and `p_wr_ready` both 1) with `p_par_err`=1 and `cfg_p_per`=1, `p_perr_n` is 0 for the single cycle between edges k+1 and k+2. `p_perr_n` is never 0 for a phase accepted with `cfg_p_per`=0.
- R2: `p_perr_oe` and `s_perr_oe` are 1 in every cycle in which their error line is 0, and also in the one cycle after the last such cycle, when the line is driven back to 1. Otherwise they are 0.
- R3: An accepted primary data phase with `p_par_err`=1 sets `st_p_det_par` at that edge, whatever the value of `cfg_p_per`.
- R4: Downstream words leave on `s_out_*` in the order they were accepted. `s_out_bad_par` for each word equals the `p_par_err` it was accepted with, including for back-to-back phases with mixed error flags.
- R5: `p_wr_ready` does not depend on `p_par_err`. Words with bad parity are accepted like any other. Ready drops only while BUF_DEPTH words are held, and a write offered while ready is 0 is not stored.
- R6: The upstream path mirrors R1 to R4, using `s_wr_*`, `s_par_err`, `cfg_s_per`, `s_perr_n`, `st_s_det_par` and `p_out_bad_par`.
- R7: In a cycle with `dn_wr_active`=1 and `s_perr_in_n`=0, `st_s_dpd` is set if `cfg_s_per`=1 and is left unchanged if `cfg_s_per`=0.
- R8: On the first cycle of such a report, `p_serr_n` goes to 0 (with `p_serr_oe`=1) for one cycle after that edge, and `st_sig_serr` is set at the same edge. This happens only if `cfg_serr_en`=1, `cfg_pw_serr_dis`=0, `cfg_s_per`=1 and `cfg_p_per`=1.
- R9: A report held for several consecutive cycles produces one `p_serr_n` pulse only.
- R10: Each status bit stays set until its own clear strobe is 1 at a rising edge. A strobe leaves the other bits unchanged. A set and a clear at the same edge leave the bit set.
- R11: While `rst_n` is 0, all status bits are 0, all error lines are 1 with their enables 0, both output-valid signals are 0, and both ready signals are 1.
- R12: `s_perr_in_n`=0 while `dn_wr_active`=0 changes no status bit and produces no `p_serr_n` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_p_per | input | 1 | Primary parity error response enable |
| cfg_s_per | input | 1 | Secondary parity error response enable |
| cfg_serr_en | input | 1 | System error reporting enable |
| cfg_pw_serr_dis | input | 1 | Disables system error for posted-write parity events |
| p_wr_valid | input | 1 | Primary data phase offered |
| p_wr_data | input | DATA_W | Primary write data |
| p_par_err | input | 1 | Parity check failed for the primary data phase |
| p_wr_ready | output | 1 | Downstream buffer can accept a word |
| s_out_valid | output | 1 | Downstream word available for the secondary bus |
| s_out_data | output | DATA_W | Downstream word |
| s_out_bad_par | output | 1 | Regenerate bad parity for this word |
| s_out_ready | input | 1 | Secondary side consumes the word |
| s_wr_valid | input | 1 | Secondary data phase offered |
| s_wr_data | input | DATA_W | Secondary write data |
| s_par_err | input | 1 | Parity check failed for the secondary data phase |
| s_wr_ready | output | 1 | Upstream buffer can accept a word |
| p_out_valid | output | 1 | Upstream word available for the primary bus |
| p_out_data | output | DATA_W | Upstream word |
| p_out_bad_par | output | 1 | Regenerate bad parity for this word |
| p_out_ready | input | 1 | Primary side consumes the word |
| p_perr_n | output | 1 | Primary parity error line, active low |
| p_perr_oe | output | 1 | Output enable for p_perr_n |
| s_perr_n | output | 1 | Secondary parity error line, active low |
| s_perr_oe | output | 1 | Output enable for s_perr_n |
| dn_wr_active | input | 1 | Bridge is driving a downstream write on the secondary bus |
| s_perr_in_n | input | 1 | Parity error reported by the secondary target, active low |
| p_serr_n | output | 1 | Primary system error pulse, active low |
| p_serr_oe | output | 1 | Output enable for p_serr_n |
| st_p_det_par | output | 1 | Primary parity error detected (sticky) |
| st_s_det_par | output | 1 | Secondary parity error detected (sticky) |
| st_s_dpd | output | 1 | Secondary data parity reported by target (sticky) |
| st_sig_serr | output | 1 | System error signaled (sticky) |
| clr_p_det_par | input | 1 | Write-one-to-clear for st_p_det_par |
| clr_s_det_par | input | 1 | Write-one-to-clear for st_s_det_par |
| clr_s_dpd | input | 1 | Write-one-to-clear for st_s_dpd |
| clr_sig_serr | input | 1 | Write-one-to-clear for st_sig_serr |

## Verification
The bench checks the error-line latency one cycle early, on time and one cycle late. A pipeline that is one stage short or long would show the line low in the wrong cycle or not at all. It walks all sixteen combinations of the four system-error conditions, so a gate that drops or inverts any one term fires in a row where it should stay quiet, or stays quiet where it should fire. It sends back-to-back words with mixed error flags and fills the buffer to its limit with bad words. A flag kept as a single register instead of per word, or a ready signal that looks at parity, would then show a wrong flag or a refused word. It also holds the target's report for several cycles, sends a report outside a downstream write, and clears one status bit while setting another at the same edge. These catch repeated pulses, an ungated report, and a clear that wins over a set.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  // Positions of the sticky status bits inside the status vector.
  typedef enum logic [1:0] {
    ST_P_DET    = 2'd0,
    ST_S_DET    = 2'd1,
    ST_S_DPD    = 2'd2,
    ST_SIG_SERR = 2'd3
  } st_idx_e;

  localparam int unsigned ST_NUM = 4;
endpackage

// File: rtl/pwp_post_fifo.sv
// Posted-write buffer: each entry holds a data word and its bad-parity flag.
module pwp_post_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_bad,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_bad,
  input  logic              out_ready
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned EW = DATA_W + 1;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push, pop;

  assign in_ready  = (cnt_q != CW'(DEPTH));
  assign out_valid = (cnt_q != '0);
  assign {out_bad, out_data} = mem[rd_q];

  always_comb begin
    push  = in_valid & in_ready;
    pop   = out_valid & out_ready;
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage has no reset; the write enable is the accepted phase.
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= {in_bad, in_data};
  end
endmodule

// File: rtl/pwp_perr_pipe.sv
// Two-stage delay from an erroneous data phase to the active-low error line,
// with one extra driven-high cycle before release.
module pwp_perr_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_err,
  input  logic per_en,
  output logic perr_n,
  output logic perr_oe
);
  logic stg_q, stg_d;
  logic act_q, act_d;
  logic tail_q, tail_d;

  always_comb begin
    stg_d  = phase_err & per_en;
    act_d  = stg_q;
    tail_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= 1'b0;
      act_q  <= 1'b0;
      tail_q <= 1'b0;
    end else begin
      stg_q  <= stg_d;
      act_q  <= act_d;
      tail_q <= tail_d;
    end
  end

  assign perr_n  = ~act_q;
  assign perr_oe = act_q | tail_q;
endmodule

// File: rtl/pwp_serr_gate.sv
// Reacts to the secondary target's parity report during a downstream write.
module pwp_serr_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic dn_wr_active,
  input  logic s_perr_in_n,
  input  logic cfg_serr_en,
  input  logic cfg_pw_serr_dis,
  input  logic cfg_s_per,
  input  logic cfg_p_per,
  output logic dpd_set,
  output logic serr_set,
  output logic serr_n,
  output logic serr_oe
);
  logic evt, evt_q;
  logic serr_q, serr_d;
  logic gates_ok;

  always_comb begin
    evt      = dn_wr_active & ~s_perr_in_n;
    gates_ok = cfg_serr_en & ~cfg_pw_serr_dis & cfg_s_per & cfg_p_per;
    dpd_set  = evt & cfg_s_per;
    serr_set = evt & ~evt_q & gates_ok;
    serr_d   = serr_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      serr_q <= 1'b0;
    end else begin
      evt_q  <= evt;
      serr_q <= serr_d;
    end
  end

  assign serr_n  = ~serr_q;
  assign serr_oe = serr_q;
endmodule

// File: rtl/pwp_sticky.sv
// Bank of sticky status bits; set has priority over write-one-to-clear.
module pwp_sticky #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q_q, q_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb q_d[i] = set_i[i] | (q_q[i] & ~clr_i[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_q[i] <= 1'b0;
      else        q_q[i] <= q_d[i];
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/pw_parity_guard.sv
module pw_parity_guard
  import pwp_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_p_per,
  input  logic              cfg_s_per,
  input  logic              cfg_serr_en,
  input  logic              cfg_pw_serr_dis,
  input  logic              p_wr_valid,
  input  logic [DATA_W-1:0] p_wr_data,
  input  logic              p_par_err,
  output logic              p_wr_ready,
  output logic              s_out_valid,
  output logic [DATA_W-1:0] s_out_data,
  output logic              s_out_bad_par,
  input  logic              s_out_ready,
  input  logic              s_wr_valid,
  input  logic [DATA_W-1:0] s_wr_data,
  input  logic              s_par_err,
  output logic              s_wr_ready,
  output logic              p_out_valid,
  output logic [DATA_W-1:0] p_out_data,
  output logic              p_out_bad_par,
  input  logic              p_out_ready,
  output logic              p_perr_n,
  output logic              p_perr_oe,
  output logic              s_perr_n,
  output logic              s_perr_oe,
  input  logic              dn_wr_active,
  input  logic              s_perr_in_n,
  output logic              p_serr_n,
  output logic              p_serr_oe,
  output logic              st_p_det_par,
  output logic              st_s_det_par,
  output logic              st_s_dpd,
  output logic              st_sig_serr,
  input  logic              clr_p_det_par,
  input  logic              clr_s_det_par,
  input  logic              clr_s_dpd,
  input  logic              clr_sig_serr
);
  logic              p_err_phase, s_err_phase;
  logic              dpd_set, serr_set;
  logic [ST_NUM-1:0] st_set, st_clr, st_q;

  // An accepted phase with a failed parity check; acceptance ignores parity.
  assign p_err_phase = p_wr_valid & p_wr_ready & p_par_err;
  assign s_err_phase = s_wr_valid & s_wr_ready & s_par_err;

  // Downstream posted path: primary target side to secondary initiator side.
  pwp_post_fifo #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_dn_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (p_wr_valid),
    .in_data   (p_wr_data),
    .in_bad    (p_par_err),
    .in_ready  (p_wr_ready),
    .out_valid (s_out_valid),
    .out_data  (s_out_data),
    .out_bad   (s_out_bad_par),
    .out_ready (s_out_ready)
  );

  // Upstream posted path: secondary target side to primary initiator side.
  pwp_post_fifo #(.DATA_W(DATA_W), .DEPTH(BUF_DEPTH)) u_up_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s_wr_valid),
    .in_data   (s_wr_data),
    .in_bad    (s_par_err),
    .in_ready  (s_wr_ready),
    .out_valid (p_out_valid),
    .out_data  (p_out_data),
    .out_bad   (p_out_bad_par),
    .out_ready (p_out_ready)
  );

  pwp_perr_pipe u_p_perr (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_err (p_err_phase),
    .per_en    (cfg_p_per),
    .perr_n    (p_perr_n),
    .perr_oe   (p_perr_oe)
  );

  pwp_perr_pipe u_s_perr (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_err (s_err_phase),
    .per_en    (cfg_s_per),
    .perr_n    (s_perr_n),
    .perr_oe   (s_perr_oe)
  );

  pwp_serr_gate u_serr (
    .clk             (clk),
    .rst_n           (rst_n),
    .dn_wr_active    (dn_wr_active),
    .s_perr_in_n     (s_perr_in_n),
    .cfg_serr_en     (cfg_serr_en),
    .cfg_pw_serr_dis (cfg_pw_serr_dis),
    .cfg_s_per       (cfg_s_per),
    .cfg_p_per       (cfg_p_per),
    .dpd_set         (dpd_set),
    .serr_set        (serr_set),
    .serr_n          (p_serr_n),
    .serr_oe         (p_serr_oe)
  );

  always_comb begin
    st_set              = '0;
    st_clr              = '0;
    st_set[ST_P_DET]    = p_err_phase;
    st_set[ST_S_DET]    = s_err_phase;
    st_set[ST_S_DPD]    = dpd_set;
    st_set[ST_SIG_SERR] = serr_set;
    st_clr[ST_P_DET]    = clr_p_det_par;
    st_clr[ST_S_DET]    = clr_s_det_par;
    st_clr[ST_S_DPD]    = clr_s_dpd;
    st_clr[ST_SIG_SERR] = clr_sig_serr;
  end

  pwp_sticky #(.N(ST_NUM)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (st_set),
    .clr_i (st_clr),
    .q_o   (st_q)
  );

  assign st_p_det_par = st_q[ST_P_DET];
  assign st_s_det_par = st_q[ST_S_DET];
  assign st_s_dpd     = st_q[ST_S_DPD];
  assign st_sig_serr  = st_q[ST_SIG_SERR];
endmodule

// File: rtl/pw_parity_guard_chk.sv
module pw_parity_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic p_wr_valid,
  input logic p_wr_ready,
  input logic p_par_err,
  input logic cfg_p_per,
  input logic cfg_s_per,
  input logic cfg_serr_en,
  input logic cfg_pw_serr_dis,
  input logic p_perr_n,
  input logic p_perr_oe,
  input logic st_p_det_par,
  input logic dn_wr_active,
  input logic s_perr_in_n,
  input logic p_serr_n,
  input logic st_sig_serr
);
  // Edges seen since reset release, saturating, so no check reaches before it.
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= 2'd0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  // R1
  p_perr_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && $past(p_wr_valid && p_wr_ready && p_par_err && cfg_p_per, 2))
      |-> !p_perr_n);

  // R1
  p_perr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2 && !p_perr_n)
      |-> $past(p_wr_valid && p_wr_ready && p_par_err && cfg_p_per, 2));

  // R2
  p_perr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1 && $past(!p_perr_n)) |-> p_perr_oe);

  // R3
  p_det_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1 && $past(p_wr_valid && p_wr_ready && p_par_err)) |-> st_p_det_par);

  // R8
  serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd1 && !p_serr_n)
      |-> $past(cfg_serr_en && !cfg_pw_serr_dis && cfg_s_per && cfg_p_per
                && dn_wr_active && !s_perr_in_n));

  // R8
  serr_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_serr_n |-> st_sig_serr);

  // R9
  serr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !p_serr_n |=> p_serr_n);
endmodule

bind pw_parity_guard pw_parity_guard_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .p_wr_valid      (p_wr_valid),
  .p_wr_ready      (p_wr_ready),
  .p_par_err       (p_par_err),
  .cfg_p_per       (cfg_p_per),
  .cfg_s_per       (cfg_s_per),
  .cfg_serr_en     (cfg_serr_en),
  .cfg_pw_serr_dis (cfg_pw_serr_dis),
  .p_perr_n        (p_perr_n),
  .p_perr_oe       (p_perr_oe),
  .st_p_det_par    (st_p_det_par),
  .dn_wr_active    (dn_wr_active),
  .s_perr_in_n     (s_perr_in_n),
  .p_serr_n        (p_serr_n),
  .st_sig_serr     (st_sig_serr)
);

// File: tb/tb_pw_parity_guard.sv
`timescale 1ns/1ps
module tb_pw_parity_guard;
  localparam int unsigned DW    = 32;
  localparam int unsigned DEPTH = 4;

  // {serr_en, pw_dis, s_per, p_per, expected serr pulse, expected dpd}
  localparam logic [5:0] SERR_VEC [16] = '{
    6'b0000_00, 6'b0001_00, 6'b0010_01, 6'b0011_01,
    6'b0100_00, 6'b0101_00, 6'b0110_01, 6'b0111_01,
    6'b1000_00, 6'b1001_00, 6'b1010_01, 6'b1011_11,
    6'b1100_00, 6'b1101_00, 6'b1110_01, 6'b1111_01
  };

  logic clk, rst_n;
  logic cfg_p_per, cfg_s_per, cfg_serr_en, cfg_pw_serr_dis;
  logic p_wr_valid, p_par_err, p_wr_ready;
  logic [DW-1:0] p_wr_data, s_out_data, s_wr_data, p_out_data;
  logic s_out_valid, s_out_bad_par, s_out_ready;
  logic s_wr_valid, s_par_err, s_wr_ready;
  logic p_out_valid, p_out_bad_par, p_out_ready;
  logic p_perr_n, p_perr_oe, s_perr_n, s_perr_oe;
  logic dn_wr_active, s_perr_in_n, p_serr_n, p_serr_oe;
  logic st_p_det_par, st_s_det_par, st_s_dpd, st_sig_serr;
  logic clr_p_det_par, clr_s_det_par, clr_s_dpd, clr_sig_serr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  pw_parity_guard #(.DATA_W(DW), .BUF_DEPTH(DEPTH)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_all();
    {clr_p_det_par, clr_s_det_par, clr_s_dpd, clr_sig_serr} = 4'hF;
    tick();
    {clr_p_det_par, clr_s_det_par, clr_s_dpd, clr_sig_serr} = 4'h0;
  endtask

  task automatic drain_dn(input logic [31:0] data, input logic bad);
    chk("R4 s_out_valid", 32'(s_out_valid), 32'd1);
    chk("R4 s_out_data", s_out_data, data);
    chk("R4 s_out_bad_par", 32'(s_out_bad_par), 32'(bad));
    s_out_ready = 1'b1;
    tick();
    s_out_ready = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {cfg_p_per, cfg_s_per, cfg_serr_en, cfg_pw_serr_dis} = 4'b0;
    p_wr_valid = 0; p_par_err = 0; p_wr_data = '0; s_out_ready = 0;
    s_wr_valid = 0; s_par_err = 0; s_wr_data = '0; p_out_ready = 0;
    dn_wr_active = 0; s_perr_in_n = 1;
    {clr_p_det_par, clr_s_det_par, clr_s_dpd, clr_sig_serr} = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk("R11 status", {28'd0, st_p_det_par, st_s_det_par, st_s_dpd, st_sig_serr}, 32'd0);
    chk("R11 lines", {29'd0, p_perr_n, s_perr_n, p_serr_n}, 32'd7);
    chk("R11 oe", {29'd0, p_perr_oe, s_perr_oe, p_serr_oe}, 32'd0);
    chk("R11 valid", {30'd0, s_out_valid, p_out_valid}, 32'd0);
    chk("R11 ready", {30'd0, p_wr_ready, s_wr_ready}, 32'd3);
    rst_n = 1'b1;
    tick();

    // R1 R2 R3 R4: back-to-back good, bad, good with response enabled
    cfg_p_per = 1'b1;
    p_wr_valid = 1; p_wr_data = 32'hA0A0_0001; p_par_err = 0;
    tick();
    chk("R1 no early perr", 32'(p_perr_n), 32'd1);
    p_wr_data = 32'hB0B0_0002; p_par_err = 1;
    tick();
    chk("R1 good word no perr", 32'(p_perr_n), 32'd1);
    chk("R3 det set", 32'(st_p_det_par), 32'd1);
    p_wr_data = 32'hC0C0_0003; p_par_err = 0;
    tick();
    p_wr_valid = 0; p_par_err = 0;
    chk("R1 perr two clocks after", 32'(p_perr_n), 32'd0);
    chk("R2 oe while low", 32'(p_perr_oe), 32'd1);
    tick();
    chk("R1 perr one clock only", 32'(p_perr_n), 32'd1);
    chk("R2 oe release cycle", 32'(p_perr_oe), 32'd1);
    tick();
    chk("R2 oe off", 32'(p_perr_oe), 32'd0);
    drain_dn(32'hA0A0_0001, 1'b0);
    drain_dn(32'hB0B0_0002, 1'b1);
    drain_dn(32'hC0C0_0003, 1'b0);
    chk("R4 empty", 32'(s_out_valid), 32'd0);

    // R1 R3: response disabled, detection still recorded
    clear_all();
    chk("R10 cleared", 32'(st_p_det_par), 32'd0);
    cfg_p_per = 1'b0;
    p_wr_valid = 1; p_wr_data = 32'hD0D0_0004; p_par_err = 1;
    tick();
    p_wr_valid = 0; p_par_err = 0;
    for (int k = 0; k < 3; k++) begin
      chk("R1 no perr when disabled", 32'(p_perr_n), 32'd1);
      tick();
    end
    chk("R3 det without response", 32'(st_p_det_par), 32'd1);
    drain_dn(32'hD0D0_0004, 1'b1);

    // R5: fill with bad words, then an extra write is refused
    for (int k = 0; k < DEPTH; k++) begin
      p_wr_valid = 1; p_wr_data = 32'h5500_0000 + 32'(k); p_par_err = 1;
      chk("R5 ready with bad parity", 32'(p_wr_ready), 32'd1);
      tick();
    end
    chk("R5 ready low when full", 32'(p_wr_ready), 32'd0);
    p_wr_data = 32'hDEAD_BEEF;
    tick();
    p_wr_valid = 0; p_par_err = 0;
    for (int k = 0; k < DEPTH; k++) drain_dn(32'h5500_0000 + 32'(k), 1'b1);
    chk("R5 refused word not stored", 32'(s_out_valid), 32'd0);

    // R6 upstream with response on
    clear_all();
    cfg_s_per = 1'b1;
    s_wr_valid = 1; s_wr_data = 32'h7777_0001; s_par_err = 1;
    tick();
    s_wr_valid = 0; s_par_err = 0;
    chk("R6 s_perr not early", 32'(s_perr_n), 32'd1);
    tick();
    chk("R6 s_perr low", 32'(s_perr_n), 32'd0);
    chk("R6 s_perr_oe", 32'(s_perr_oe), 32'd1);
    chk("R6 s det", 32'(st_s_det_par), 32'd1);
    chk("R6 p_out_data", p_out_data, 32'h7777_0001);
    chk("R6 p_out_bad_par", 32'(p_out_bad_par), 32'd1);
    p_out_ready = 1; tick(); p_out_ready = 0;
    chk("R6 s_perr released", 32'(s_perr_n), 32'd1);
    // R6 upstream with response off
    clear_all();
    cfg_s_per = 1'b0;
    s_wr_valid = 1; s_wr_data = 32'h7777_0002; s_par_err = 1;
    tick();
    s_wr_valid = 0; s_par_err = 0;
    tick();
    chk("R6 no s_perr when disabled", 32'(s_perr_n), 32'd1);
    chk("R6 s det without response", 32'(st_s_det_par), 32'd1);
    p_out_ready = 1; tick(); p_out_ready = 0;

    // R7 R8: all sixteen gating combinations
    for (int i = 0; i < 16; i++) begin
      {cfg_serr_en, cfg_pw_serr_dis, cfg_s_per, cfg_p_per} = SERR_VEC[i][5:2];
      clear_all();
      dn_wr_active = 1; s_perr_in_n = 0;
      tick();
      chk("R8 serr pulse", 32'(p_serr_n), 32'(!SERR_VEC[i][1]));
      chk("R8 serr oe", 32'(p_serr_oe), 32'(SERR_VEC[i][1]));
      chk("R8 sig status", 32'(st_sig_serr), 32'(SERR_VEC[i][1]));
      chk("R7 dpd status", 32'(st_s_dpd), 32'(SERR_VEC[i][0]));
      dn_wr_active = 0; s_perr_in_n = 1;
      tick();
      chk("R8 serr one cycle", 32'(p_serr_n), 32'd1);
    end

    // R9: sustained report gives a single pulse
    {cfg_serr_en, cfg_pw_serr_dis, cfg_s_per, cfg_p_per} = 4'b1011;
    clear_all();
    dn_wr_active = 1; s_perr_in_n = 0;
    tick();
    chk("R9 first pulse", 32'(p_serr_n), 32'd0);
    tick();
    chk("R9 no repeat", 32'(p_serr_n), 32'd1);
    tick();
    chk("R9 no repeat later", 32'(p_serr_n), 32'd1);
    dn_wr_active = 0; s_perr_in_n = 1;
    tick();

    // R12: report outside a downstream write is ignored
    clear_all();
    s_perr_in_n = 0;
    tick();
    chk("R12 no serr", 32'(p_serr_n), 32'd1);
    chk("R12 no status", {30'd0, st_s_dpd, st_sig_serr}, 32'd0);
    s_perr_in_n = 1;
    tick();

    // R10: independent clears and set-over-clear priority
    p_wr_valid = 1; p_wr_data = 32'h1; p_par_err = 1;
    s_wr_valid = 1; s_wr_data = 32'h2; s_par_err = 1;
    dn_wr_active = 1; s_perr_in_n = 0;
    tick();
    p_wr_valid = 0; s_wr_valid = 0; p_par_err = 0; s_par_err = 0;
    dn_wr_active = 0; s_perr_in_n = 1;
    s_out_ready = 1; p_out_ready = 1; tick(); s_out_ready = 0; p_out_ready = 0;
    chk("R10 all set", {28'd0, st_p_det_par, st_s_det_par, st_s_dpd, st_sig_serr}, 32'hF);
    clr_s_dpd = 1; tick(); clr_s_dpd = 0;
    chk("R10 one cleared", {28'd0, st_p_det_par, st_s_det_par, st_s_dpd, st_sig_serr}, 32'hD);
    p_wr_valid = 1; p_wr_data = 32'h3; p_par_err = 1; clr_p_det_par = 1;
    tick();
    p_wr_valid = 0; p_par_err = 0; clr_p_det_par = 0;
    chk("R10 set wins", 32'(st_p_det_par), 32'd1);
    s_out_ready = 1; tick(); s_out_ready = 0;
    repeat (3) tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule